// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a clocked static memory of 2^ADDR_W words, each word made of four 9-bit byte lanes (36 bits by default). Every control, the address and the write data are captured on the rising clock edge. An internal two-bit burst counter can step through four neighbouring words from one loaded address, either in linear or in exclusive-or (interleaved) order. A new address may also be loaded on every cycle with no lost cycle.

A static strap picks the read latency. In flow-through mode the stored word goes straight from the array to the output. In pipelined mode it passes through a rising-edge output register first. Writes cover either the whole word (global write) or only the selected byte lanes. The bidirectional data bus is split into `dqIn`, `dqOut` and the drive enable `dqOe`. The drive enable follows an asynchronous output enable. A sleep input gates the drive enable and keeps the stored contents.

Top module: `sbsram_top`

## Requirements
- R1: Inputs act only at a rising edge. During the cycle in which a read command is presented, `dqOe` keeps the value left by the previous command.
- R2: With `pipeMode`=0, the word for a read captured at edge k is driven between edge k and edge k+1. A four-beat burst therefore returns data in 2-1-1-1 cycles from the cycle the address is presented.
- R3: With `pipeMode`=1, the word for a read captured at edge k is driven between edge k+1 and edge k+2. A burst returns data in 3-1-1-1 cycles.
- R4: With `globalWr`=1, all four lanes of the addressed word are written, whatever `byteWrEn` and `byteSel` are.
- R5: With `globalWr`=0 and `byteWrEn`=1, only the lanes whose `byteSel` bit is 1 are written. Bit g selects data bits [9g+8:9g]. With no lane selected, the cycle is a read.
- R6: With `burstLinear`=1, beat n of a burst accesses the loaded address with its two low bits replaced by (start + n) mod 4. The upper bits stay fixed.
- R7: With `burstLinear`=0, beat n accesses the loaded address with its two low bits exclusive-ored with n.
- R8: With `addrLoad`=0 and `advance`=0 during an active access, the same address is accessed again.
- R9: A deselect (`addrLoad`=1, `chipSel`=0) ends the access. `dqOe` falls at the first edge where no read data is due. In pipelined mode the last read word is driven for exactly one cycle.
- R10: `outEn`=0 forces `dqOe` low at once, without waiting for a clock edge. The read still occurs and the burst counter still advances.
- R11: While `sleep`=1, `dqOe` is low, commands act as deselects, writes are ignored, and stored contents are retained.
- R12: After reset, `dqOe` is low and no access is active.
- R13: Single reads loaded on consecutive cycles return their words on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of control state |
| pipeMode | input | 1 | Read latency strap: 1 pipelined, 0 flow-through |
| burstLinear | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Low-power request; output off, writes ignored |
| outEn | input | 1 | Asynchronous output enable |
| chipSel | input | 1 | Selects the device when an address is loaded |
| addrLoad | input | 1 | Loads `addr` and starts a new access |
| advance | input | 1 | Steps the burst counter when no address is loaded |
| globalWr | input | 1 | Writes the whole word |
| byteWrEn | input | 1 | Enables lane writes selected by `byteSel` |
| byteSel | input | LANES | Per-lane write select |
| addr | input | ADDR_W | Word address |
| dqIn | input | WORD_W | Write data |
| dqOut | output | WORD_W | Read data |
| dqOe | output | 1 | Drive enable for `dqOut` |

## Verification
The scoreboard expects a value on the bus, or an undriven bus, in every cycle. A design with the wrong latency in either mode shows its data a cycle early or late, and that breaks the 2-1-1-1 or 3-1-1-1 check. A design with an extra output stage after a deselect keeps `dqOe` high for one cycle too long. A counter that wraps beyond the two low bits, or that uses the wrong order, returns the wrong word on the third and fourth beats. Reads with the output disabled, followed by enabled beats, catch a counter that stalls on those reads. A registered output enable misses the mid-cycle change. A write during sleep that reaches the array shows up in a later read, and so does a global write that honours the lane selects.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  parameter int LANES  = 4;
  parameter int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // strobes from control to datapath, valid for the cycle after capture
  typedef struct packed {
    logic             rdStrobe;
    logic             wrStrobe;
    logic [LANES-1:0] laneMask;
  } memStrobe_t;
endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linear,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] beat;
  logic [BURST_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      beat     <= '0;
    end else if (load) begin
      baseAddr <= addrIn;
      beat     <= '0;
    end else if (step) begin
      beat     <= beat + 1'b1;
    end
  end

  always_comb begin
    lowBits = linear ? (baseAddr[BURST_W-1:0] + beat) : (baseAddr[BURST_W-1:0] ^ beat);
    addrOut = {baseAddr[ADDR_W-1:BURST_W], lowBits};
  end

  // R6: a linear step moves the low bits by one and leaves the upper bits alone
  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && linear) |=> (!linear ||
      ((addrOut[BURST_W-1:0] == BURST_W'($past(addrOut[BURST_W-1:0]) + 1'b1)) &&
       (addrOut[ADDR_W-1:BURST_W] == $past(addrOut[ADDR_W-1:BURST_W])))));

  // R8: no load and no step keeps the address
  a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !step) |=> ($stable(addrOut) || !$stable(linear)));
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl import sbsram_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleep,
  input  logic             chipSel,
  input  logic             addrLoad,
  input  logic             advance,
  input  logic             globalWr,
  input  logic             byteWrEn,
  input  logic [LANES-1:0] byteSel,
  output logic             ctrLoad,
  output logic             ctrStep,
  output memStrobe_t       strb
);
  logic             active;
  logic             goIdle;
  logic             nextActive;
  logic             nextWr;
  logic [LANES-1:0] nextMask;

  always_comb begin
    goIdle     = sleep | (addrLoad & ~chipSel);
    ctrLoad    = ~goIdle & addrLoad;
    ctrStep    = ~goIdle & ~addrLoad & active & advance;
    nextActive = ~goIdle & (addrLoad | active);
    nextMask   = globalWr ? {LANES{1'b1}} : (byteWrEn ? byteSel : '0);
    nextWr     = nextActive & (|nextMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      strb   <= '0;
    end else begin
      active        <= nextActive;
      strb.wrStrobe <= nextWr;
      strb.rdStrobe <= nextActive & ~nextWr;
      strb.laneMask <= nextWr ? nextMask : '0;
    end
  end

  // R11: a command seen during sleep never writes
  a_r11_sleep_no_write: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !strb.wrStrobe);

  // R4: global write covers every lane
  a_r4_global_all_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (globalWr && addrLoad && chipSel && !sleep) |=> (strb.wrStrobe && (&strb.laneMask)));

  // R9: deselect leaves no access pending
  a_r9_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    (addrLoad && !chipSel) |=> (!strb.rdStrobe && !strb.wrStrobe));
endmodule

// File: rtl/sbsram_datapath.sv
module sbsram_datapath import sbsram_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              outEn,
  input  logic              sleep,
  input  memStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dqIn,
  output logic [WORD_W-1:0] dqOut,
  output logic              dqOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] wrData;
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] pipeData;
  logic              pipeValid;

  // write data is captured with its command
  always_ff @(posedge clk) wrData <= dqIn;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wrStrobe && strb.laneMask[g])
        laneMem[addr] <= wrData[g*LANE_W +: LANE_W];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeValid <= 1'b0;
      pipeData  <= '0;
    end else begin
      pipeValid <= strb.rdStrobe;
      if (strb.rdStrobe) pipeData <= rdWord;
    end
  end

  always_comb begin
    dqOut = pipeMode ? pipeData : rdWord;
    dqOe  = outEn & ~sleep & (pipeMode ? pipeValid : strb.rdStrobe);
  end

  // R3: a read in flight reaches the output stage one edge later
  a_r3_pipe_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStrobe |=> pipeValid);

  // R9: without a read in flight the output stage releases at the next edge
  a_r9_single_release: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStrobe |=> !pipeValid);
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top import sbsram_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              burstLinear,
  input  logic              sleep,
  input  logic              outEn,
  input  logic              chipSel,
  input  logic              addrLoad,
  input  logic              advance,
  input  logic              globalWr,
  input  logic              byteWrEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dqIn,
  output logic [WORD_W-1:0] dqOut,
  output logic              dqOe
);
  memStrobe_t        strb;
  logic              ctrLoad;
  logic              ctrStep;
  logic [ADDR_W-1:0] memAddr;

  sbsram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleep(sleep), .chipSel(chipSel),
    .addrLoad(addrLoad), .advance(advance), .globalWr(globalWr),
    .byteWrEn(byteWrEn), .byteSel(byteSel),
    .ctrLoad(ctrLoad), .ctrStep(ctrStep), .strb(strb)
  );

  sbsram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk(clk), .rstN(rstN), .linear(burstLinear), .load(ctrLoad),
    .step(ctrStep), .addrIn(addr), .addrOut(memAddr)
  );

  sbsram_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .outEn(outEn),
    .sleep(sleep), .strb(strb), .addr(memAddr), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: tb/sbsram_top_tb.sv
module sbsram_top_tb;
  localparam int AW = 8;
  localparam int WW = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pipeMode = 1'b0, burstLinear = 1'b1, sleep = 1'b0, outEn = 1'b1;
  logic chipSel = 1'b0, addrLoad = 1'b0, advance = 1'b0;
  logic globalWr = 1'b0, byteWrEn = 1'b0;
  logic [3:0] byteSel = '0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] dqIn = '0;
  logic [WW-1:0] dqOut;
  logic dqOe;

  sbsram_top u_dut (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .burstLinear(burstLinear),
    .sleep(sleep), .outEn(outEn), .chipSel(chipSel), .addrLoad(addrLoad),
    .advance(advance), .globalWr(globalWr), .byteWrEn(byteWrEn),
    .byteSel(byteSel), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    bit          isRead;
    logic [35:0] data;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [35:0] refMem [256];
  int          cyc = 0;
  int          nChk = 0, nFail = 0;
  bit          bAct = 0;
  logic [7:0]  bBase = '0;
  logic [1:0]  bBeat = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops the items due in this cycle and compares them with the bus
  item_t it;
  bit    expOe;
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it    = sb.pop_front();
      expOe = it.isRead && outEn && !sleep;
      chk(it.due == cyc, {it.tag, " due"}, 36'(it.due), 36'(cyc));
      chk(dqOe == expOe, {it.tag, " oe"}, 36'(dqOe), 36'(expOe));
      if (expOe) chk(dqOut == it.data, {it.tag, " data"}, dqOut, it.data);
    end
  end

  // driver: one command per cycle; the expected result goes into the queue
  task automatic op(input bit ld, input bit cs, input bit adv, input bit gw, input bit bwe,
                    input logic [3:0] bsel, input logic [7:0] a, input logic [35:0] d,
                    input string tag);
    logic [7:0]  eff;
    logic [3:0]  mask;
    bit          isWr;
    item_t       ni;
    chipSel = cs; addrLoad = ld; advance = adv; globalWr = gw;
    byteWrEn = bwe; byteSel = bsel; addr = a; dqIn = d;
    if (sleep || (ld && !cs)) bAct = 0;
    else if (ld) begin bAct = 1; bBase = a; bBeat = 2'd0; end
    else if (bAct && adv) bBeat = bBeat + 2'd1;
    eff  = burstLinear ? {bBase[7:2], bBase[1:0] + bBeat} : {bBase[7:2], bBase[1:0] ^ bBeat};
    mask = gw ? 4'hF : (bwe ? bsel : 4'h0);
    isWr = bAct && (mask != 4'h0);
    if (isWr)
      for (int g = 0; g < 4; g++)
        if (mask[g]) refMem[eff][g*9 +: 9] = d[g*9 +: 9];
    ni.due    = cyc + (pipeMode ? 2 : 1);
    ni.isRead = bAct && !isWr;
    ni.data   = refMem[eff];
    ni.tag    = tag;
    sb.push_back(ni);
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    op(1, 1, 0, 0, 0, 4'h0, a, '0, tag);
  endtask
  task automatic nxt(input bit adv, input string tag);
    op(0, 1, adv, 0, 0, 4'h0, 8'h00, '0, tag);
  endtask
  task automatic dsel(input string tag);
    op(1, 0, 0, 0, 0, 4'h0, 8'h00, '0, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0; chipSel = 0; addrLoad = 0; advance = 0; globalWr = 0; byteWrEn = 0;
    bAct = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(dqOe == 1'b0, "R12 oe after reset", 36'(dqOe), 36'h0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    // flow-through, linear
    doReset();
    dsel("R9");
    op(1, 1, 0, 1, 0, 4'h0, 8'h10, 36'h123456789, "R4");
    op(1, 1, 0, 1, 0, 4'h0, 8'h20, 36'h0A0A0A0A0, "R6");
    op(0, 1, 1, 1, 0, 4'h0, 8'h00, 36'h1B1B1B1B1, "R6");
    op(0, 1, 1, 1, 0, 4'h0, 8'h00, 36'h2C2C2C2C2, "R6");
    op(0, 1, 1, 1, 0, 4'h0, 8'h00, 36'h3D3D3D3D3, "R6");
    op(1, 1, 0, 0, 1, 4'b0101, 8'h10, 36'hFFFFFFFFF, "R5");
    op(1, 1, 0, 0, 1, 4'b0000, 8'h10, 36'h000000000, "R5");
    dsel("R1");
    rd(8'h10, "R2");
    rd(8'h22, "R6"); nxt(1, "R6"); nxt(1, "R6"); nxt(1, "R6");
    rd(8'h21, "R8"); nxt(0, "R8"); nxt(0, "R8"); nxt(1, "R8");
    dsel("R9"); dsel("R9");
    rd(8'h20, "R13"); rd(8'h23, "R13"); rd(8'h10, "R13"); rd(8'h21, "R13");
    dsel("R9");
    // interleaved order
    burstLinear = 1'b0;
    rd(8'h23, "R7"); nxt(1, "R7"); nxt(1, "R7"); nxt(1, "R7");
    op(1, 1, 0, 1, 0, 4'h0, 8'h31, 36'h111111111, "R7");
    op(0, 1, 1, 1, 0, 4'h0, 8'h00, 36'h222222222, "R7");
    op(0, 1, 1, 1, 0, 4'h0, 8'h00, 36'h333333333, "R7");
    op(0, 1, 1, 1, 0, 4'h0, 8'h00, 36'h444444444, "R7");
    rd(8'h30, "R7"); rd(8'h31, "R7"); rd(8'h32, "R7"); rd(8'h33, "R7");
    dsel("R9"); dsel("R9"); dsel("R9");
    // pipelined, linear
    burstLinear = 1'b1;
    pipeMode = 1'b1;
    doReset();
    dsel("R3");
    rd(8'h20, "R3"); nxt(1, "R3"); nxt(1, "R3"); nxt(1, "R3");
    dsel("R9"); dsel("R9");
    rd(8'h10, "R9"); dsel("R9"); dsel("R9"); dsel("R9");
    // dummy reads with the output disabled still advance the counter
    outEn = 1'b0;
    rd(8'h20, "R10"); nxt(1, "R10"); nxt(1, "R10"); nxt(1, "R10");
    outEn = 1'b1;
    dsel("R10"); dsel("R10");
    // sleep: output off at once, writes dropped, contents kept
    rd(8'h21, "R11");
    sleep = 1'b1;
    op(1, 1, 0, 1, 0, 4'h0, 8'h10, 36'hBADBADBAD, "R11");
    dsel("R11");
    sleep = 1'b0;
    dsel("R11");
    rd(8'h10, "R11"); rd(8'h21, "R11");
    dsel("R9"); dsel("R9"); dsel("R9");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule